// File: doc/BRIEF.md
# Mode-banked general register file

This block holds sixteen general-purpose registers of a processor core. The upper registers are duplicated per processor mode. A 5-bit mode input is sampled on every clock edge. When the new mode belongs to a different bank than the current one, the block moves the affected registers in a single edge: the departing bank's copies go into shadow storage, and the arriving bank's copies become the live registers. How deep the banking goes depends on the bank. The fast-interrupt bank owns its own r8 to r14. The other privileged banks own only r13 and r14. System mode shares the user bank. Any unmapped mode code lands in a dummy bank, and that bank hands out zeros.

The core reads the live registers through two combinational read ports and writes them through one write port. A debug port reads or writes a register as seen from any named mode. It does not disturb the current mode. If the named mode shares the current bank, or the register is not banked, the port reaches the live register. Otherwise it reaches the shadow copy that the named mode would use.

Every port is a plain single-cycle access with no handshake. A read returns data in the same cycle, and a write takes effect at the next rising edge. Nothing can stall.

Top module: `banked_gpr_file`

## Requirements
- R1: A synchronous active-high reset sets the mode to 5'b10011 (supervisor) and clears every live register and every shadow register to zero.
- R2: The mode code selects the bank as follows. Codes 0 and 16 select user. Codes 1 and 17 select fast-interrupt. Codes 2 and 18 select interrupt. Codes 3 and 19 select supervisor. Code 23 selects abort and code 27 selects undefined. Code 31 (system) shares the user bank. Every other code selects the dummy bank.
- R3: The two read ports return the addressed live register combinationally (address = register number 0..15). A write port access becomes visible on the read ports after the next rising edge.
- R4: On every edge outside reset, the current-mode output takes the value of the mode input.
- R5: Leaving the fast-interrupt bank saves live r8 to r14 into its shadow. Entering it loads r8 to r14 from that shadow. Registers r0 to r7 and r15 never move.
- R6: When a non-fast, non-dummy bank is left for the fast-interrupt bank, live r8 to r12 are saved into the user shadow. When the fast-interrupt bank is left for such a bank, r8 to r12 are restored from the user shadow.
- R7: When one bank is left for another and neither is fast-interrupt nor dummy, only r13 and r14 move. They are saved into the old bank's shadow and loaded from the new bank's shadow, and r8 to r12 stay as they are.
- R8: A mode change between codes that map to the same bank (for example user, system and code 0) moves no register.
- R9: Entering the dummy bank forces live r8 to r14 to zero. Leaving it clears the dummy bank's shadow r8 to r14. Live r8 to r12 keep their values when the dummy bank is left for a non-fast bank.
- R10: A write-port access in the same cycle as a mode change lands in the live register of the new mode. It overrides the value restored for that register, and the old bank's saved copy holds the value from before the write.
- R11: A debug access reaches the live register when the named mode maps to the current bank or when the register is r0 to r7 or r15. Otherwise, r13 and r14 reach the named bank's shadow. For r8 to r12, the access reaches the named bank's shadow when that bank is fast-interrupt or dummy. When the named bank is another one, it reaches the user shadow if the current bank is fast-interrupt, and the live register if not.
- R12: A debug write is ignored in a cycle where the mode input differs from the current mode. When a debug write and a write-port access target the same live register in one cycle, the debug data is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Requested processor mode, taken at every edge |
| cur_mode_o | output | 5 | Mode currently in force |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register number |
| wr_data | input | DATA_W | Write port data |
| dbg_we | input | 1 | Debug write enable |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_addr | input | 4 | Debug register number |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Debug read data, combinational |

## Verification
The properties assume that the mode, write and debug inputs are stable and defined at each rising edge, and that reset is held for at least one edge before the first access. They further assume that no debug write arrives in a cycle with a mode change, since such a write is dropped by design and the properties rely on that. The bench changes its inputs only at falling edges and never leaves an input undriven. It makes exactly one kind of access per step, except for the vectors that combine a write or a debug write with a mode change, which exercise those cases on purpose.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DUM = 3'd6
  } bank_e;

  localparam int NUM_BANKS = 7;
  localparam int NUM_GPR   = 16;
  localparam int ADDR_W    = $clog2(NUM_GPR);
  localparam int MODE_W    = 5;

  // r8..r12: banked only by fast-interrupt (and dummy) banks
  localparam int LO_FIRST  = 8;
  localparam int LO_CNT    = 5;
  localparam int LO_IDX_W  = $clog2(LO_CNT);
  // r13..r14: banked by every bank
  localparam int HI_FIRST  = 13;
  localparam int HI_CNT    = 2;
  localparam int HI_IDX_W  = $clog2(HI_CNT);

  localparam logic [MODE_W-1:0] MODE_AT_RESET = 5'b10011;

  typedef enum logic [1:0] {
    DSEL_LIVE = 2'd0,
    DSEL_LO   = 2'd1,
    DSEL_HI   = 2'd2
  } dbg_sel_e;

endpackage

// File: rtl/gprf_mode_map.sv
module gprf_mode_map
  import gprf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);

  always_comb begin
    unique case (mode)
      5'd0,  5'd16: bank = BK_USR;
      5'd1,  5'd17: bank = BK_FIQ;
      5'd2,  5'd18: bank = BK_IRQ;
      5'd3,  5'd19: bank = BK_SVC;
      5'd23:        bank = BK_ABT;
      5'd27:        bank = BK_UND;
      5'd31:        bank = BK_USR;   // system shares user storage
      default:      bank = BK_DUM;
    endcase
  end

endmodule

// File: rtl/gprf_shadow.sv
module gprf_shadow #(
  parameter int DATA_W = 32,
  parameter int CNT    = 2,
  parameter int IDX_W  = (CNT > 1) ? $clog2(CNT) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        save_en,
  input  logic                        clr,
  input  logic [CNT-1:0][DATA_W-1:0]  save_d,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_d,
  output logic [CNT-1:0][DATA_W-1:0]  q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (save_en) begin
      q <= save_d;
    end else if (wr_en && (32'(wr_idx) < CNT)) begin
      q[wr_idx] <= wr_d;
    end
  end

  // R9: a cleared shadow reads zero afterwards
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  // R5: a save captures the departing live values
  p_save_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (save_en && !clr) |=> (q == $past(save_d)));

endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import gprf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           mode_i,
  output logic [4:0]           cur_mode_o,
  input  logic [3:0]           rd_a_addr,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [3:0]           rd_b_addr,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [3:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 dbg_we,
  input  logic [4:0]           dbg_mode,
  input  logic [3:0]           dbg_addr,
  input  logic [DATA_W-1:0]    dbg_wdata,
  output logic [DATA_W-1:0]    dbg_rdata
);

  typedef logic [LO_CNT-1:0][DATA_W-1:0] lo_vec_t;
  typedef logic [HI_CNT-1:0][DATA_W-1:0] hi_vec_t;

  logic [DATA_W-1:0] rf_q [NUM_GPR];
  logic [DATA_W-1:0] rf_d [NUM_GPR];
  logic [MODE_W-1:0] mode_q;

  bank_e old_bk, new_bk, dbg_bk;
  logic  chg, swap;

  lo_vec_t live_lo;
  hi_vec_t live_hi;
  lo_vec_t lo_q [NUM_BANKS];
  hi_vec_t hi_q [NUM_BANKS];

  logic [NUM_BANKS-1:0] lo_save, hi_save, bank_clr, lo_wr, hi_wr;

  dbg_sel_e              dsel;
  bank_e                 dsh_bk;
  logic                  dbg_ok, dbg_is_lo, dbg_is_hi;
  logic [LO_IDX_W-1:0]   lo_idx;
  logic [HI_IDX_W-1:0]   hi_idx;

  // ---------------- bank decode ----------------
  gprf_mode_map u_map_cur (.mode(mode_q),   .bank(old_bk));
  gprf_mode_map u_map_new (.mode(mode_i),   .bank(new_bk));
  gprf_mode_map u_map_dbg (.mode(dbg_mode), .bank(dbg_bk));

  assign chg  = (mode_i != mode_q);
  assign swap = chg && (old_bk != new_bk);

  always_comb begin
    for (int i = 0; i < LO_CNT; i++) live_lo[i] = rf_q[LO_FIRST+i];
    for (int i = 0; i < HI_CNT; i++) live_hi[i] = rf_q[HI_FIRST+i];
  end

  // ---------------- save / clear control ----------------
  always_comb begin
    lo_save  = '0;
    hi_save  = '0;
    bank_clr = '0;
    if (swap) begin
      unique case (old_bk)
        BK_FIQ: begin
          lo_save[BK_FIQ] = 1'b1;
          hi_save[BK_FIQ] = 1'b1;
        end
        BK_DUM: bank_clr[BK_DUM] = 1'b1;
        default: begin
          hi_save[old_bk] = 1'b1;
          if (new_bk == BK_FIQ) lo_save[BK_USR] = 1'b1;
        end
      endcase
    end
  end

  // ---------------- debug routing ----------------
  assign dbg_ok    = dbg_we && !chg;
  assign dbg_is_lo = (dbg_addr >= ADDR_W'(LO_FIRST)) && (dbg_addr < ADDR_W'(HI_FIRST));
  assign dbg_is_hi = (dbg_addr >= ADDR_W'(HI_FIRST)) && (dbg_addr < ADDR_W'(HI_FIRST + HI_CNT));
  assign lo_idx    = LO_IDX_W'(dbg_addr - ADDR_W'(LO_FIRST));
  assign hi_idx    = HI_IDX_W'(dbg_addr - ADDR_W'(HI_FIRST));

  always_comb begin
    dsel   = DSEL_LIVE;
    dsh_bk = dbg_bk;
    if (dbg_bk != old_bk) begin
      if (dbg_is_hi) begin
        dsel = DSEL_HI;
      end else if (dbg_is_lo) begin
        if (dbg_bk == BK_FIQ || dbg_bk == BK_DUM) begin
          dsel = DSEL_LO;
        end else if (old_bk == BK_FIQ) begin
          dsel   = DSEL_LO;
          dsh_bk = BK_USR;
        end
      end
    end
  end

  always_comb begin
    lo_wr = '0;
    hi_wr = '0;
    if (dbg_ok && dsel == DSEL_LO) lo_wr[dsh_bk] = 1'b1;
    if (dbg_ok && dsel == DSEL_HI) hi_wr[dsh_bk] = 1'b1;
  end

  always_comb begin
    unique case (dsel)
      DSEL_LO: dbg_rdata = lo_q[dsh_bk][lo_idx];
      DSEL_HI: dbg_rdata = hi_q[dsh_bk][hi_idx];
      default: dbg_rdata = rf_q[dbg_addr];
    endcase
  end

  // ---------------- shadow storage per bank ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gprf_shadow #(.DATA_W(DATA_W), .CNT(HI_CNT)) u_hi (
      .clk    (clk),
      .rst    (rst),
      .save_en(hi_save[b]),
      .clr    (bank_clr[b]),
      .save_d (live_hi),
      .wr_en  (hi_wr[b]),
      .wr_idx (hi_idx),
      .wr_d   (dbg_wdata),
      .q      (hi_q[b])
    );
    if (b == int'(BK_USR) || b == int'(BK_FIQ) || b == int'(BK_DUM)) begin : g_lo
      gprf_shadow #(.DATA_W(DATA_W), .CNT(LO_CNT)) u_lo (
        .clk    (clk),
        .rst    (rst),
        .save_en(lo_save[b]),
        .clr    (bank_clr[b]),
        .save_d (live_lo),
        .wr_en  (lo_wr[b]),
        .wr_idx (lo_idx),
        .wr_d   (dbg_wdata),
        .q      (lo_q[b])
      );
    end else begin : g_no_lo
      assign lo_q[b] = '0;
    end
  end

  // ---------------- live register next state ----------------
  always_comb begin
    for (int i = 0; i < NUM_GPR; i++) rf_d[i] = rf_q[i];
    if (swap) begin
      unique case (new_bk)
        BK_FIQ: begin
          for (int i = 0; i < LO_CNT; i++) rf_d[LO_FIRST+i] = lo_q[BK_FIQ][i];
          for (int i = 0; i < HI_CNT; i++) rf_d[HI_FIRST+i] = hi_q[BK_FIQ][i];
        end
        BK_DUM: begin
          for (int i = 0; i < LO_CNT; i++) rf_d[LO_FIRST+i] = '0;
          for (int i = 0; i < HI_CNT; i++) rf_d[HI_FIRST+i] = '0;
        end
        default: begin
          if (old_bk == BK_FIQ) begin
            for (int i = 0; i < LO_CNT; i++) rf_d[LO_FIRST+i] = lo_q[BK_USR][i];
          end
          for (int i = 0; i < HI_CNT; i++) rf_d[HI_FIRST+i] = hi_q[new_bk][i];
        end
      endcase
    end
    if (wr_en) rf_d[wr_addr] = wr_data;
    if (dbg_ok && dsel == DSEL_LIVE) rf_d[dbg_addr] = dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_GPR; i++) rf_q[i] <= '0;
      mode_q <= MODE_AT_RESET;
    end else begin
      for (int i = 0; i < NUM_GPR; i++) rf_q[i] <= rf_d[i];
      mode_q <= mode_i;
    end
  end

  assign cur_mode_o = mode_q;
  assign rd_a_data  = rf_q[rd_a_addr];
  assign rd_b_data  = rf_q[rd_b_addr];

  // ---------------- properties ----------------
  // R4: the mode register follows a requested change
  p_mode_follow_r4: assert property (@(posedge clk) disable iff (rst)
    chg |=> (mode_q == $past(mode_i)));

  // R5: entering fast-interrupt loads r8 from its shadow
  p_fiq_load_r5: assert property (@(posedge clk) disable iff (rst)
    (swap && new_bk == BK_FIQ && !wr_en) |=> (rf_q[LO_FIRST] == $past(lo_q[BK_FIQ][0])));

  // R6: going into fast-interrupt parks r8 in the user shadow
  p_user_park_r6: assert property (@(posedge clk) disable iff (rst)
    (swap && new_bk == BK_FIQ && old_bk != BK_DUM) |=> (lo_q[BK_USR][0] == $past(rf_q[LO_FIRST])));

  // R8: same-bank change leaves r13 untouched
  p_same_bank_r8: assert property (@(posedge clk) disable iff (rst)
    (chg && !swap && !wr_en) |=> (rf_q[HI_FIRST] == $past(rf_q[HI_FIRST])));

  // R9: entering the dummy bank zeroes r14
  p_dummy_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (swap && new_bk == BK_DUM && !wr_en) |=> (rf_q[HI_FIRST+1] == '0));

  // R10: a write alongside a bank swap lands in the new view
  p_swap_write_r10: assert property (@(posedge clk) disable iff (rst)
    (swap && wr_en) |=> (rf_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: tb/test_banked_gpr_file.sv
`timescale 1ns/1ps
module test_banked_gpr_file;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    mode_d;
  logic [4:0]    cur_mode_o;
  logic [3:0]    rd_a_addr, rd_b_addr, wr_addr, dbg_addr;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data, dbg_wdata, dbg_rdata;
  logic          wr_en, dbg_we;
  logic [4:0]    dbg_mode;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  banked_gpr_file #(.DATA_W(DW)) i_banked_gpr_file (
    .clk(clk), .rst(rst), .mode_i(mode_d), .cur_mode_o(cur_mode_o),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_we(dbg_we), .dbg_mode(dbg_mode), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  localparam logic [2:0] K_MODE = 3'd0, K_WR = 3'd1, K_RD = 3'd2, K_DR = 3'd3,
                         K_DW = 3'd4, K_MW = 3'd5, K_BOTH = 3'd6, K_MD = 3'd7;

  typedef struct packed {
    logic [2:0]  kind;
    logic [4:0]  mode;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    '{K_MODE, 5'h10, 4'd0,  32'h0,        4'd4 },  // R4 svc -> usr
    '{K_WR,   5'h00, 4'd0,  32'h000000A0, 4'd3 },  // R3
    '{K_WR,   5'h00, 4'd8,  32'h000000A8, 4'd3 },
    '{K_WR,   5'h00, 4'd13, 32'h000000AD, 4'd3 },
    '{K_WR,   5'h00, 4'd14, 32'h000000AE, 4'd3 },
    '{K_RD,   5'h00, 4'd8,  32'h000000A8, 4'd3 },  // R3
    '{K_MODE, 5'h11, 4'd0,  32'h0,        4'd5 },  // R5 enter fiq
    '{K_RD,   5'h00, 4'd8,  32'h0,        4'd5 },
    '{K_RD,   5'h00, 4'd13, 32'h0,        4'd5 },
    '{K_WR,   5'h00, 4'd8,  32'h000000F8, 4'd5 },
    '{K_WR,   5'h00, 4'd14, 32'h000000FE, 4'd5 },
    '{K_DR,   5'h10, 4'd8,  32'h000000A8, 4'd11},  // R11 user r8 in shadow
    '{K_DR,   5'h10, 4'd13, 32'h000000AD, 4'd11},
    '{K_MODE, 5'h12, 4'd0,  32'h0,        4'd6 },  // R6 fiq -> irq
    '{K_RD,   5'h00, 4'd8,  32'h000000A8, 4'd6 },
    '{K_DR,   5'h11, 4'd8,  32'h000000F8, 4'd5 },
    '{K_DR,   5'h11, 4'd14, 32'h000000FE, 4'd5 },
    '{K_WR,   5'h00, 4'd13, 32'h0000001D, 4'd7 },
    '{K_MODE, 5'h13, 4'd0,  32'h0,        4'd7 },  // R7 irq -> svc
    '{K_RD,   5'h00, 4'd8,  32'h000000A8, 4'd7 },
    '{K_DR,   5'h12, 4'd13, 32'h0000001D, 4'd7 },
    '{K_MODE, 5'h1F, 4'd0,  32'h0,        4'd2 },  // R2 system
    '{K_RD,   5'h00, 4'd13, 32'h000000AD, 4'd2 },
    '{K_WR,   5'h00, 4'd13, 32'h0000005A, 4'd8 },
    '{K_MODE, 5'h10, 4'd0,  32'h0,        4'd8 },  // R8 sys -> usr
    '{K_RD,   5'h00, 4'd13, 32'h0000005A, 4'd8 },
    '{K_MODE, 5'h00, 4'd0,  32'h0,        4'd8 },  // R8 code 0
    '{K_RD,   5'h00, 4'd13, 32'h0000005A, 4'd8 },
    '{K_MODE, 5'h01, 4'd0,  32'h0,        4'd2 },  // R2 code 1
    '{K_RD,   5'h00, 4'd8,  32'h000000F8, 4'd2 },
    '{K_MODE, 5'h17, 4'd0,  32'h0,        4'd6 },  // R6 fiq -> abort
    '{K_RD,   5'h00, 4'd8,  32'h000000A8, 4'd6 },
    '{K_WR,   5'h00, 4'd14, 32'h000000AB, 4'd7 },
    '{K_MODE, 5'h1B, 4'd0,  32'h0,        4'd7 },  // R7 abort -> undef
    '{K_RD,   5'h00, 4'd14, 32'h0,        4'd7 },
    '{K_DR,   5'h17, 4'd14, 32'h000000AB, 4'd2 },
    '{K_WR,   5'h00, 4'd14, 32'h0000000E, 4'd9 },
    '{K_MODE, 5'h14, 4'd0,  32'h0,        4'd9 },  // R9 enter dummy
    '{K_RD,   5'h00, 4'd8,  32'h0,        4'd9 },
    '{K_DR,   5'h1B, 4'd14, 32'h0000000E, 4'd9 },
    '{K_WR,   5'h00, 4'd9,  32'h00000099, 4'd9 },
    '{K_MODE, 5'h10, 4'd0,  32'h0,        4'd9 },  // R9 leave dummy
    '{K_RD,   5'h00, 4'd9,  32'h00000099, 4'd9 },
    '{K_RD,   5'h00, 4'd13, 32'h0000005A, 4'd9 },
    '{K_DW,   5'h04, 4'd10, 32'h00000077, 4'd11},  // R11 dummy shadow
    '{K_DR,   5'h04, 4'd10, 32'h00000077, 4'd11},
    '{K_MODE, 5'h04, 4'd0,  32'h0,        4'd9 },
    '{K_RD,   5'h00, 4'd10, 32'h0,        4'd9 },
    '{K_MODE, 5'h10, 4'd0,  32'h0,        4'd9 },
    '{K_DR,   5'h04, 4'd10, 32'h0,        4'd9 },  // R9 shadow cleared
    '{K_MW,   5'h13, 4'd13, 32'h000000C3, 4'd10},  // R10
    '{K_RD,   5'h00, 4'd13, 32'h000000C3, 4'd10},
    '{K_DR,   5'h10, 4'd13, 32'h0000005A, 4'd10},
    '{K_MODE, 5'h10, 4'd0,  32'h0,        4'd10},
    '{K_DR,   5'h13, 4'd13, 32'h000000C3, 4'd10},
    '{K_BOTH, 5'h10, 4'd2,  32'h11111111, 4'd12},  // R12
    '{K_RD,   5'h00, 4'd2,  32'hEEEEEEEE, 4'd12},
    '{K_MD,   5'h12, 4'd3,  32'h00000033, 4'd12},
    '{K_RD,   5'h00, 4'd3,  32'h0,        4'd12},
    '{K_RD,   5'h00, 4'd13, 32'h0000001D, 4'd7 },
    '{K_DW,   5'h13, 4'd13, 32'h00000044, 4'd11},
    '{K_DR,   5'h13, 4'd13, 32'h00000044, 4'd11},
    '{K_DR,   5'h1B, 4'd0,  32'h000000A0, 4'd11}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en  = 1'b0;
    dbg_we = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    case (v.kind)
      K_MODE: begin
        mode_d = v.mode;
        tick();
        check(int'(v.req), 32'(cur_mode_o), 32'(v.mode), "mode");
      end
      K_WR: begin
        wr_en = 1'b1; wr_addr = v.addr; wr_data = v.data;
        tick();
      end
      K_RD: begin
        rd_a_addr = v.addr; rd_b_addr = v.addr;
        #1;
        check(int'(v.req), rd_a_data, v.data, "read A");
        check(int'(v.req), rd_b_data, v.data, "read B");
      end
      K_DR: begin
        dbg_mode = v.mode; dbg_addr = v.addr;
        #1;
        check(int'(v.req), dbg_rdata, v.data, "debug read");
      end
      K_DW: begin
        dbg_we = 1'b1; dbg_mode = v.mode; dbg_addr = v.addr; dbg_wdata = v.data;
        tick();
      end
      K_MW: begin
        mode_d = v.mode; wr_en = 1'b1; wr_addr = v.addr; wr_data = v.data;
        tick();
      end
      K_BOTH: begin
        wr_en = 1'b1; wr_addr = v.addr; wr_data = v.data;
        dbg_we = 1'b1; dbg_mode = v.mode; dbg_addr = v.addr; dbg_wdata = ~v.data;
        tick();
      end
      default: begin  // K_MD
        mode_d = v.mode;
        dbg_we = 1'b1; dbg_mode = v.mode; dbg_addr = v.addr; dbg_wdata = v.data;
        tick();
      end
    endcase
  endtask

  initial begin
    rst = 1'b1; mode_d = 5'h13; wr_en = 1'b0; dbg_we = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    dbg_mode = 5'h13; dbg_addr = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    check(1, 32'(cur_mode_o), 32'h13, "reset mode");
    rd_a_addr = 4'd0; rd_b_addr = 4'd14; #1;
    check(1, rd_a_data, 32'h0, "reset r0");
    check(1, rd_b_data, 32'h0, "reset r14");

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: reset mid-run clears live and shadow state
    mode_d = 5'h13;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    check(1, 32'(cur_mode_o), 32'h13, "mode after reset");
    rd_a_addr = 4'd0; rd_b_addr = 4'd2; #1;
    check(1, rd_a_data, 32'h0, "r0 after reset");
    check(1, rd_b_data, 32'h0, "r2 after reset");
    dbg_mode = 5'h11; dbg_addr = 4'd8; #1;
    check(1, dbg_rdata, 32'h0, "fiq r8 shadow after reset");
    dbg_mode = 5'h10; dbg_addr = 4'd13; #1;
    check(1, dbg_rdata, 32'h0, "user r13 shadow after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule